// File: doc/BRIEF.md
# Self-Invalidating Race-Free L1 Coherence Controller

This block tracks coherence state for the lines of a small private L1 cache. It serves a protocol that relies on software being free of data races. Each line is always in one of three stable states: Invalid, Valid or Registered. There are no intermediate states and no bookkeeping of other caches' copies.

A local read of a missing line asks the fabric for the data. A local write that does not already own the line asks the directory to register this core as the holder of the up-to-date copy. When another core registers a line, the directory sends a notice, and the controller drops its own registration. When the directory forwards a read for a line this cache owns, the controller answers that it will supply the line. Copies of data that other cores may have changed are not invalidated one by one. Instead, software issues a sweep command at each synchronisation point. In one cycle, the sweep discards every line this core did not write.

The data arrays, the directory and any software region hints are outside this block. The controller only emits the request and response pulses. Every line's state is exported on a flat vector.

Top module: `sic_ctrl`

## Requirements
- R1: After reset every line is Invalid and all output pulses are low. The state encoding is Invalid=2'b00, Valid=2'b01, Registered=2'b10. Line i occupies bits [2i+1:2i] of `state_vec_o`, and 2'b11 never appears.
- R2: A local read of an Invalid line makes it Valid and raises `fetch_req_o` for one cycle, on the cycle after the read, with `fetch_idx_o` naming the line. A read of a Valid or Registered line changes nothing and raises no fetch.
- R3: A local write to an Invalid or Valid line makes it Registered and raises `reg_req_o` for one cycle, on the cycle after the write, with `reg_idx_o` naming the line.
- R4: A local write to a line that is already Registered leaves it Registered and raises no registration request.
- R5: A remote registration notice turns a Registered line Invalid. It leaves Valid and Invalid lines unchanged, so readers are never invalidated by another core's write.
- R6: A forwarded read raises exactly one of `fwd_ack_o` and `fwd_nack_o` on the next cycle. `fwd_ack_o` is raised when the line was Registered before that edge, with `fwd_line_o` naming the line. The forwarded read never changes the line's state.
- R7: A sweep command turns every line that is not Registered into Invalid in a single cycle and keeps Registered lines. `sinv_done_o` is high for exactly the one cycle after the command.
- R8: Within one cycle the steps apply in a fixed order: the sweep first, then the remote notice, then the local access. A simultaneous local read and write is handled as a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd_i | input | 1 | Local read access |
| cpu_wr_i | input | 1 | Local write access |
| cpu_idx_i | input | IDX_W | Line addressed by the local access |
| rmt_wr_i | input | 1 | Remote registration notice from the directory |
| rmt_idx_i | input | IDX_W | Line named by the remote notice |
| fwd_rd_i | input | 1 | Read forwarded by the directory |
| fwd_idx_i | input | IDX_W | Line named by the forwarded read |
| sinv_i | input | 1 | Self-invalidation sweep command |
| fetch_req_o | output | 1 | Data fetch request pulse |
| fetch_idx_o | output | IDX_W | Line to fetch |
| reg_req_o | output | 1 | Registration request pulse |
| reg_idx_o | output | IDX_W | Line to register |
| fwd_ack_o | output | 1 | This cache will supply the forwarded line |
| fwd_nack_o | output | 1 | This cache does not own the forwarded line |
| fwd_line_o | output | IDX_W | Line that the forward answer refers to |
| sinv_done_o | output | 1 | Sweep finished pulse |
| state_vec_o | output | 2*NUM_LINES | Current state of every line |

## Verification
The bench checks that a write to an already Registered line stays silent; a design that got this wrong would flood the directory with duplicate registrations. It checks that a remote notice leaves Valid lines alone; a design that got this wrong would be acting like a sharer-invalidation protocol. It checks that a sweep keeps Registered lines; a design that got this wrong would lose the only current copy of the data. Same-cycle collisions are also exercised: a sweep together with a read miss, a remote notice together with a local write on the same line, and a forwarded read together with a remote notice. A design that got the order of these steps wrong would leave a line in the wrong state or answer a forwarded read wrongly.

// File: rtl/sic_pkg.sv
package sic_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'b00,
        LN_VAL = 2'b01,
        LN_REG = 2'b10
    } line_st_e;

endpackage

// File: rtl/sic_line_fsm.sv
module sic_line_fsm
    import sic_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     loc_rd,
    input  logic     loc_wr,
    input  logic     rmt_wr,
    input  logic     sweep,
    output line_st_e st_o,
    output logic     fetch_o,
    output logic     regreq_o
);

    line_st_e st_q, st_d, mid;

    always_comb begin
        // step 1: sweep keeps only lines this core wrote
        mid = st_q;
        if (sweep && mid != LN_REG) begin
            mid = LN_INV;
        end
        // step 2: another core took ownership
        if (rmt_wr && mid == LN_REG) begin
            mid = LN_INV;
        end
        // step 3: local access, write dominates
        st_d     = mid;
        fetch_o  = 1'b0;
        regreq_o = 1'b0;
        if (loc_wr) begin
            if (mid != LN_REG) begin
                st_d     = LN_REG;
                regreq_o = 1'b1;
            end
        end else if (loc_rd && mid == LN_INV) begin
            st_d    = LN_VAL;
            fetch_o = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= LN_INV;
        end else begin
            st_q <= st_d;
        end
    end

    assign st_o = st_q;

endmodule

// File: rtl/sic_fwd_lookup.sv
module sic_fwd_lookup
    import sic_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic [2*NUM_LINES-1:0] st_vec,
    input  logic [IDX_W-1:0]       idx,
    output logic                   owned
);

    always_comb begin
        owned = 1'b0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (idx == IDX_W'(i) && st_vec[2*i +: 2] == LN_REG) begin
                owned = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sic_ctrl.sv
module sic_ctrl
    import sic_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cpu_rd_i,
    input  logic                   cpu_wr_i,
    input  logic [IDX_W-1:0]       cpu_idx_i,
    input  logic                   rmt_wr_i,
    input  logic [IDX_W-1:0]       rmt_idx_i,
    input  logic                   fwd_rd_i,
    input  logic [IDX_W-1:0]       fwd_idx_i,
    input  logic                   sinv_i,
    output logic                   fetch_req_o,
    output logic [IDX_W-1:0]       fetch_idx_o,
    output logic                   reg_req_o,
    output logic [IDX_W-1:0]       reg_idx_o,
    output logic                   fwd_ack_o,
    output logic                   fwd_nack_o,
    output logic [IDX_W-1:0]       fwd_line_o,
    output logic                   sinv_done_o,
    output logic [2*NUM_LINES-1:0] state_vec_o
);

    typedef struct packed {
        logic             fetch;
        logic [IDX_W-1:0] fetch_idx;
        logic             regreq;
        logic [IDX_W-1:0] reg_idx;
        logic             ack;
        logic             nack;
        logic [IDX_W-1:0] fwd_line;
        logic             done;
    } evt_t;

    logic [NUM_LINES-1:0]   fetch_vec;
    logic [NUM_LINES-1:0]   regreq_vec;
    logic [2*NUM_LINES-1:0] st_vec;
    logic                   fwd_owned;
    evt_t                   ev_d, ev_q;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        line_st_e st_w;
        sic_line_fsm u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .loc_rd   (cpu_rd_i && cpu_idx_i == IDX_W'(g)),
            .loc_wr   (cpu_wr_i && cpu_idx_i == IDX_W'(g)),
            .rmt_wr   (rmt_wr_i && rmt_idx_i == IDX_W'(g)),
            .sweep    (sinv_i),
            .st_o     (st_w),
            .fetch_o  (fetch_vec[g]),
            .regreq_o (regreq_vec[g])
        );
        assign st_vec[2*g +: 2] = st_w;
    end

    sic_fwd_lookup #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W)
    ) u_fwd (
        .st_vec (st_vec),
        .idx    (fwd_idx_i),
        .owned  (fwd_owned)
    );

    always_comb begin
        ev_d           = '0;
        ev_d.fetch     = |fetch_vec;
        ev_d.fetch_idx = cpu_idx_i;
        ev_d.regreq    = |regreq_vec;
        ev_d.reg_idx   = cpu_idx_i;
        ev_d.ack       = fwd_rd_i && fwd_owned;
        ev_d.nack      = fwd_rd_i && !fwd_owned;
        ev_d.fwd_line  = fwd_idx_i;
        ev_d.done      = sinv_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q <= '0;
        end else begin
            ev_q <= ev_d;
        end
    end

    assign fetch_req_o = ev_q.fetch;
    assign fetch_idx_o = ev_q.fetch_idx;
    assign reg_req_o   = ev_q.regreq;
    assign reg_idx_o   = ev_q.reg_idx;
    assign fwd_ack_o   = ev_q.ack;
    assign fwd_nack_o  = ev_q.nack;
    assign fwd_line_o  = ev_q.fwd_line;
    assign sinv_done_o = ev_q.done;
    assign state_vec_o = st_vec;

endmodule

// File: rtl/sic_ctrl_chk.sv
module sic_ctrl_chk #(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cpu_rd_i,
    input logic                   cpu_wr_i,
    input logic [IDX_W-1:0]       cpu_idx_i,
    input logic                   rmt_wr_i,
    input logic [IDX_W-1:0]       rmt_idx_i,
    input logic                   fwd_rd_i,
    input logic [IDX_W-1:0]       fwd_idx_i,
    input logic                   sinv_i,
    input logic                   fetch_req_o,
    input logic [IDX_W-1:0]       fetch_idx_o,
    input logic                   reg_req_o,
    input logic [IDX_W-1:0]       reg_idx_o,
    input logic                   fwd_ack_o,
    input logic                   fwd_nack_o,
    input logic [IDX_W-1:0]       fwd_line_o,
    input logic                   sinv_done_o,
    input logic [2*NUM_LINES-1:0] state_vec_o
);

    function automatic logic [1:0] st_at(input logic [2*NUM_LINES-1:0] v,
                                         input logic [IDX_W-1:0] idx);
        logic [1:0] r;
        r = 2'b00;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (idx == IDX_W'(i)) r = v[2*i +: 2];
        end
        return r;
    endfunction

    int ill_cnt;
    int val_cnt;
    always_comb begin
        ill_cnt = 0;
        val_cnt = 0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (state_vec_o[2*i +: 2] == 2'b11) ill_cnt++;
            if (state_vec_o[2*i +: 2] == 2'b01) val_cnt++;
        end
    end

    a_r1_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
        ill_cnt == 0);

    a_r2_fetch_leaves_valid: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_o |-> st_at(state_vec_o, fetch_idx_o) == 2'b01);

    a_r3_regreq_owned: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req_o |-> st_at(state_vec_o, reg_idx_o) == 2'b10);

    a_r3_regreq_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req_o |-> $past(cpu_wr_i));

    a_r6_fwd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_ack_o && fwd_nack_o));

    a_r6_fwd_answered: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_rd_i |=> (fwd_ack_o || fwd_nack_o));

    a_r6_fwd_owned_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_rd_i && st_at(state_vec_o, fwd_idx_i) == 2'b10) |=> fwd_ack_o);

    a_r7_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        sinv_i |=> sinv_done_o);

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        !sinv_i |=> !sinv_done_o);

    a_r7_sweep_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (sinv_i && !cpu_rd_i && !cpu_wr_i) |=> val_cnt == 0);

endmodule

bind sic_ctrl sic_ctrl_chk #(
    .NUM_LINES (NUM_LINES),
    .IDX_W     (IDX_W)
) u_chk (.*);

// File: tb/sic_ctrl_bench.sv
`timescale 1ns/1ps
module sic_ctrl_bench;

    localparam int N  = 8;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_rd_i = 0, cpu_wr_i = 0, rmt_wr_i = 0, fwd_rd_i = 0, sinv_i = 0;
    logic [IW-1:0] cpu_idx_i = '0, rmt_idx_i = '0, fwd_idx_i = '0;
    logic          fetch_req_o, reg_req_o, fwd_ack_o, fwd_nack_o, sinv_done_o;
    logic [IW-1:0] fetch_idx_o, reg_idx_o, fwd_line_o;
    logic [2*N-1:0] state_vec_o;

    int checks = 0;
    int fails  = 0;

    // captured outputs one edge after an operation
    logic          c_fetch, c_reg, c_ack, c_nack, c_done;
    logic [IW-1:0] c_fidx, c_ridx, c_fline;

    always #4 clk = ~clk;

    sic_ctrl #(.NUM_LINES(N)) u_sic_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_rd_i(cpu_rd_i), .cpu_wr_i(cpu_wr_i), .cpu_idx_i(cpu_idx_i),
        .rmt_wr_i(rmt_wr_i), .rmt_idx_i(rmt_idx_i),
        .fwd_rd_i(fwd_rd_i), .fwd_idx_i(fwd_idx_i), .sinv_i(sinv_i),
        .fetch_req_o(fetch_req_o), .fetch_idx_o(fetch_idx_o),
        .reg_req_o(reg_req_o), .reg_idx_o(reg_idx_o),
        .fwd_ack_o(fwd_ack_o), .fwd_nack_o(fwd_nack_o), .fwd_line_o(fwd_line_o),
        .sinv_done_o(sinv_done_o), .state_vec_o(state_vec_o)
    );

    localparam logic [1:0] S_I = 2'b00, S_V = 2'b01, S_R = 2'b10;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] st(input int i);
        return state_vec_o[2*i +: 2];
    endfunction

    // one operation cycle; outputs captured just after the edge
    task automatic op(input logic rd, input logic wr, input int ci,
                      input logic rw, input int ri,
                      input logic fr, input int fi, input logic si);
        @(negedge clk);
        cpu_rd_i = rd; cpu_wr_i = wr; cpu_idx_i = IW'(ci);
        rmt_wr_i = rw; rmt_idx_i = IW'(ri);
        fwd_rd_i = fr; fwd_idx_i = IW'(fi);
        sinv_i = si;
        @(posedge clk);
        #1;
        c_fetch = fetch_req_o; c_fidx = fetch_idx_o;
        c_reg = reg_req_o;     c_ridx = reg_idx_o;
        c_ack = fwd_ack_o;     c_nack = fwd_nack_o; c_fline = fwd_line_o;
        c_done = sinv_done_o;
        cpu_rd_i = 0; cpu_wr_i = 0; rmt_wr_i = 0; fwd_rd_i = 0; sinv_i = 0;
    endtask

    task automatic t_reset();
        check("R1", "state vector after reset", 32'(state_vec_o), 32'h0);
        check("R1", "pulses after reset",
              {fetch_req_o, reg_req_o, fwd_ack_o, fwd_nack_o, sinv_done_o}, 0);
    endtask

    task automatic t_read();
        op(1, 0, 2, 0, 0, 0, 0, 0);
        check("R2", "miss fetch pulse", c_fetch, 1);
        check("R2", "miss fetch idx", c_fidx, 2);
        check("R2", "line2 valid", st(2), S_V);
        op(1, 0, 2, 0, 0, 0, 0, 0);
        check("R2", "hit no fetch", c_fetch, 0);
        check("R2", "hit keeps valid", st(2), S_V);
    endtask

    task automatic t_write();
        op(0, 1, 2, 0, 0, 0, 0, 0);
        check("R3", "V write reg pulse", c_reg, 1);
        check("R3", "V write idx", c_ridx, 2);
        check("R3", "line2 registered", st(2), S_R);
        op(0, 1, 5, 0, 0, 0, 0, 0);
        check("R3", "I write reg pulse", {c_reg, c_fetch}, 2'b10);
        check("R3", "line5 registered", st(5), S_R);
        op(0, 1, 5, 0, 0, 0, 0, 0);
        check("R4", "R write silent", c_reg, 0);
        check("R4", "line5 stays registered", st(5), S_R);
        op(1, 0, 5, 0, 0, 0, 0, 0);
        check("R2", "read of registered no fetch", c_fetch, 0);
        check("R2", "line5 still registered", st(5), S_R);
    endtask

    task automatic t_remote();
        op(1, 0, 1, 0, 0, 0, 0, 0);
        op(0, 0, 0, 1, 1, 0, 0, 0);
        check("R5", "remote on valid keeps valid", st(1), S_V);
        op(0, 0, 0, 1, 5, 0, 0, 0);
        check("R5", "remote on registered invalidates", st(5), S_I);
        op(0, 0, 0, 1, 0, 0, 0, 0);
        check("R5", "remote on invalid stays invalid", st(0), S_I);
        check("R5", "other lines untouched", {st(1), st(2)}, {S_V, S_R});
    endtask

    task automatic t_fwd();
        op(0, 0, 0, 0, 0, 1, 2, 0);
        check("R6", "owned forward ack/nack", {c_ack, c_nack}, 2'b10);
        check("R6", "owned forward line", c_fline, 2);
        check("R6", "owned line keeps state", st(2), S_R);
        op(0, 0, 0, 0, 0, 1, 1, 0);
        check("R6", "unowned forward ack/nack", {c_ack, c_nack}, 2'b01);
        check("R6", "valid line unchanged", st(1), S_V);
    endtask

    task automatic t_sweep();
        op(1, 0, 6, 0, 0, 0, 0, 0);
        op(0, 0, 0, 0, 0, 0, 0, 1);
        check("R7", "done pulse", c_done, 1);
        check("R7", "valid lines dropped", {st(1), st(6)}, {S_I, S_I});
        check("R7", "registered kept", st(2), S_R);
        op(0, 0, 0, 0, 0, 0, 0, 0);
        check("R7", "done lasts one cycle", c_done, 0);
    endtask

    task automatic t_order();
        op(0, 1, 3, 0, 0, 0, 0, 0);
        op(1, 0, 4, 0, 0, 0, 0, 1);
        check("R8", "sweep then read miss fetch", c_fetch, 1);
        check("R8", "sweep then read gives valid", st(4), S_V);
        op(0, 1, 3, 1, 3, 0, 0, 0);
        check("R8", "remote then write re-registers", c_reg, 1);
        check("R8", "line3 registered", st(3), S_R);
        op(1, 1, 7, 0, 0, 0, 0, 0);
        check("R8", "rd+wr acts as write", {c_reg, c_fetch}, 2'b10);
        check("R8", "line7 registered", st(7), S_R);
        op(0, 0, 0, 1, 3, 1, 3, 0);
        check("R8", "forward sees pre-notice owner", {c_ack, c_nack}, 2'b10);
        check("R8", "line3 dropped by notice", st(3), S_I);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_read();
        t_write();
        t_remote();
        t_fwd();
        t_sweep();
        t_order();
        repeat (2) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule